// File: doc/BRIEF.md
# Square Matrix Multiply Engine with Selectable Loop Order

This block multiplies two N×N matrices of 16-bit signed values. Both operands sit in small on-chip register files. The result matrix sits in an array of N² multiply-accumulate cells. A run starts with a one-cycle `start` pulse. The mode input chooses one of three loop orderings, and each ordering exposes a different amount of parallelism on the same datapath:

- **ijk** finishes one inner product before it begins the next, so one cell works per cycle.
- **jki** advances a whole result column at once, so N cells work per cycle.
- **kij** updates every result element on each k step, so all N² cells work per cycle.

Two counters run alongside. One counts the operand values read out of the register files per cycle. The other counts the multiply-accumulate operations done per cycle. Their ratio shows how much arithmetic each fetched value feeds in the chosen order.

A typical caller loads A and B one element at a time, picks a mode, and pulses `start`. It then waits for the one-cycle `done` pulse. After that it reads the N² sums through the read port and takes the two counters. Results and counters stay put until the next accepted start. The parameter N may be 2 or 4.

Top module: `mm_engine`

## Requirements
- R1: An accepted start clears every accumulator to zero in the next cycle. Each run therefore yields exactly A×B, with nothing carried over from earlier runs. Results stay readable and unchanged from `done` until the next accepted start.
- R2: Element (r,c) is written and read at address r·N+c, for both operands and for results. Each result is the exact 40-bit two's-complement sum over k of A[r][k]·B[k][c]. The three orders give bit-identical results, including for extreme operand values.
- R3: Mode code 0 selects ijk. It takes N³ step cycles, enables exactly one cell per cycle, and fetches 2 values per cycle. Totals are N³ MACs and 2N³ fetches.
- R4: Mode code 1 selects jki. It takes N² step cycles, enables N cells per cycle (one result column), and fetches N+1 values per cycle.
- R5: Mode code 2 selects kij. It takes N step cycles, enables all N² cells per cycle, and fetches 2N values per cycle.
- R6: `done` is high for exactly one cycle, S clock edges after the edge that accepted start, where S is the mode's step count. In that cycle the final sums are already readable.
- R7: After reset, both counters read zero. An accepted start clears them. While running, the MAC counter grows each cycle by the number of active cells. Both counters hold their totals while idle.
- R8: While a run is in progress, a start pulse is ignored, a mode change is ignored, and operand writes are ignored.
- R9: Mode code 3 runs the ijk order, with the same step count and counter totals as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_a_we | input | 1 | Write enable for operand A |
| ld_b_we | input | 1 | Write enable for operand B |
| ld_addr | input | 2·log2(N) | Operand element address, r·N+c |
| ld_data | input | 16 | Operand element value, signed |
| mode | input | 2 | Loop order: 0 ijk, 1 jki, 2 kij, 3 ijk |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | 2·log2(N) | Result element address, r·N+c |
| rd_data | output | 40 | Result element value, signed |
| fetch_count | output | CW | Operand values fetched in the current or last run |
| mac_count | output | CW | MAC operations done in the current or last run |

## Verification
The assertions check these rules on every cycle:

- The cycle after an accepted start reads zero.
- `done` never lasts two cycles.
- ijk mode never enables more than one cell.
- The MAC counter grows by exactly the number of enabled cells.
- The latched mode stays fixed for the whole run.

Some properties only the bench scenarios can show. These are the numeric sums in each order, the agreement of the three orders, and the exact latency to `done`. They also include the fetch totals, and the fact that a start, mode change or operand write during a run leaves the result untouched.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;

    // Loop ordering; code 3 on the mode pins is folded onto ORD_IJK at start.
    typedef enum logic [1:0] {
        ORD_IJK = 2'd0,
        ORD_JKI = 2'd1,
        ORD_KIJ = 2'd2
    } ord_e;

endpackage

// File: rtl/mm_opstore.sv
`timescale 1ns/1ps
// Operand register file: one write port, all elements visible in parallel.
module mm_opstore #(
    parameter int N   = 4,
    parameter int DW  = 16,
    parameter int AWD = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AWD-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  cells_o [N*N]
);
    localparam int SQ = N * N;

    logic [DW-1:0] mem_d [SQ];
    logic [DW-1:0] mem_q [SQ];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SQ; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign cells_o = mem_q;

endmodule

// File: rtl/mm_decode.sv
`timescale 1ns/1ps
// Maps the step counter to the k index, the cell enables, the end-of-run flag
// and the per-cycle fetch and MAC increments for the selected loop order.
module mm_decode
    import mm_pkg::*;
#(
    parameter int N  = 4,
    parameter int LG = 2,
    parameter int SW = 6,
    parameter int CW = 16
) (
    input  ord_e          ord,
    input  logic [SW-1:0] step,
    output logic [LG-1:0] k,
    output logic [N*N-1:0] cell_en,
    output logic          last,
    output logic [CW-1:0] fetch_inc,
    output logic [CW-1:0] mac_inc
);
    localparam int SQ = N * N;
    localparam int CU = N * N * N;

    // Step layout, least significant first: k, then j, then i (ijk only).
    logic [LG-1:0] iv;
    logic [LG-1:0] jv;

    assign k  = step[LG-1:0];
    assign jv = step[2*LG-1:LG];
    assign iv = step[3*LG-1:2*LG];

    for (genvar g = 0; g < SQ; g++) begin : g_en
        localparam logic [LG-1:0] ROW = LG'(g / N);
        localparam logic [LG-1:0] COL = LG'(g % N);
        assign cell_en[g] = (ord == ORD_IJK) ? ((iv == ROW) && (jv == COL)) :
                            (ord == ORD_JKI) ? (jv == COL) : 1'b1;
    end

    always_comb begin
        unique case (ord)
            ORD_IJK: begin
                last      = (step == SW'(CU - 1));
                fetch_inc = CW'(2);
                mac_inc   = CW'(1);
            end
            ORD_JKI: begin
                last      = (step == SW'(SQ - 1));
                fetch_inc = CW'(N + 1);
                mac_inc   = CW'(N);
            end
            default: begin
                last      = (step == SW'(N - 1));
                fetch_inc = CW'(2 * N);
                mac_inc   = CW'(SQ);
            end
        endcase
    end

endmodule

// File: rtl/mm_mac_cell.sv
`timescale 1ns/1ps
// One result element: signed 16x16 product added into a wide accumulator.
module mm_mac_cell #(
    parameter int DW  = 16,
    parameter int ACW = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [ACW-1:0] acc_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic [ACW-1:0]       acc_d;
    logic [ACW-1:0]       acc_q;

    assign prod = $signed(a) * $signed(b);

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_q + {{(ACW - PW){prod[PW-1]}}, prod};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/mm_engine.sv
`timescale 1ns/1ps
// Matrix product engine: N*N MAC cells, three selectable loop orders.
module mm_engine
    import mm_pkg::*;
#(
    parameter int N   = 4,
    parameter int DW  = 16,
    parameter int ACW = 40,
    parameter int CW  = 16,
    localparam int LG  = $clog2(N),
    localparam int AWD = 2 * LG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_a_we,
    input  logic           ld_b_we,
    input  logic [AWD-1:0] ld_addr,
    input  logic [DW-1:0]  ld_data,
    input  logic [1:0]     mode,
    input  logic           start,
    output logic           done,
    input  logic [AWD-1:0] rd_addr,
    output logic [ACW-1:0] rd_data,
    output logic [CW-1:0]  fetch_count,
    output logic [CW-1:0]  mac_count
);
    localparam int SQ = N * N;
    localparam int SW = 3 * LG;

    typedef struct packed {
        logic          run;
        ord_e          ord;
        logic [SW-1:0] step;
        logic [CW-1:0] fetch;
        logic [CW-1:0] macs;
        logic          done;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic           go;
    logic           running;
    logic [1:0]     ord_bits;
    logic [LG-1:0]  k_sel;
    logic [SQ-1:0]  cell_en;
    logic           last;
    logic [CW-1:0]  fetch_inc;
    logic [CW-1:0]  mac_inc;
    logic [DW-1:0]  a_cells [SQ];
    logic [DW-1:0]  b_cells [SQ];
    logic [ACW-1:0] acc [SQ];

    assign running  = ctl_q.run;
    assign go       = start && !ctl_q.run;
    assign ord_bits = ctl_q.ord;

    mm_opstore #(.N(N), .DW(DW), .AWD(AWD)) u_store_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ld_a_we && !ctl_q.run),
        .waddr  (ld_addr),
        .wdata  (ld_data),
        .cells_o(a_cells)
    );

    mm_opstore #(.N(N), .DW(DW), .AWD(AWD)) u_store_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ld_b_we && !ctl_q.run),
        .waddr  (ld_addr),
        .wdata  (ld_data),
        .cells_o(b_cells)
    );

    mm_decode #(.N(N), .LG(LG), .SW(SW), .CW(CW)) u_decode (
        .ord      (ctl_q.ord),
        .step     (ctl_q.step),
        .k        (k_sel),
        .cell_en  (cell_en),
        .last     (last),
        .fetch_inc(fetch_inc),
        .mac_inc  (mac_inc)
    );

    for (genvar g = 0; g < SQ; g++) begin : g_cell
        localparam int ROW = g / N;
        localparam int COL = g % N;
        logic [DW-1:0] a_op;
        logic [DW-1:0] b_op;
        assign a_op = a_cells[{LG'(ROW), k_sel}];
        assign b_op = b_cells[{k_sel, LG'(COL)}];
        mm_mac_cell #(.DW(DW), .ACW(ACW)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (go),
            .en   (ctl_q.run && cell_en[g]),
            .a    (a_op),
            .b    (b_op),
            .acc_o(acc[g])
        );
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (go) begin
            ctl_d.run   = 1'b1;
            ctl_d.ord   = (mode == 2'd3) ? ORD_IJK : ord_e'(mode);
            ctl_d.step  = '0;
            ctl_d.fetch = '0;
            ctl_d.macs  = '0;
        end else if (ctl_q.run) begin
            ctl_d.fetch = ctl_q.fetch + fetch_inc;
            ctl_d.macs  = ctl_q.macs + mac_inc;
            if (last) begin
                ctl_d.run  = 1'b0;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.step = ctl_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{run: 1'b0, ord: ORD_IJK, step: '0, fetch: '0, macs: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done        = ctl_q.done;
    assign rd_data     = acc[rd_addr];
    assign fetch_count = ctl_q.fetch;
    assign mac_count   = ctl_q.macs;

endmodule

// File: rtl/mm_engine_chk.sv
`timescale 1ns/1ps
module mm_engine_chk #(
    parameter int N   = 4,
    parameter int CW  = 16,
    parameter int ACW = 40
) (
    input logic           clk,
    input logic           rst_n,
    input logic           go,
    input logic           running,
    input logic           start,
    input logic           done,
    input logic [1:0]     ord_bits,
    input logic [N*N-1:0] cell_en,
    input logic [CW-1:0]  mac_count,
    input logic [ACW-1:0] rd_data
);
    // R1
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> rd_data == '0);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

    // R3
    ijk_one_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ord_bits == 2'd0) |-> $countones(cell_en) == 1);

    // R7
    mac_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> mac_count == $past(mac_count) + CW'($past($countones(cell_en))));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !go) |=> $stable(mac_count));

    // R8
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> $stable(ord_bits));

endmodule

bind mm_engine mm_engine_chk #(.N(N), .CW(CW), .ACW(ACW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .running  (running),
    .start    (start),
    .done     (done),
    .ord_bits (ord_bits),
    .cell_en  (cell_en),
    .mac_count(mac_count),
    .rd_data  (rd_data)
);

// File: tb/mm_engine_tb.sv
`timescale 1ns/1ps
module mm_engine_tb;
    localparam int N   = 4;
    localparam int SQ  = N * N;
    localparam int DW  = 16;
    localparam int ACW = 40;
    localparam int CW  = 16;
    localparam int AWD = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ld_a_we, ld_b_we;
    logic [AWD-1:0] ld_addr;
    logic [DW-1:0]  ld_data;
    logic [1:0]     mode;
    logic           start;
    logic           done;
    logic [AWD-1:0] rd_addr;
    logic [ACW-1:0] rd_data;
    logic [CW-1:0]  fetch_count, mac_count;

    always #4 clk = ~clk;

    mm_engine #(.N(N), .DW(DW), .ACW(ACW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_a_we(ld_a_we), .ld_b_we(ld_b_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .mode(mode), .start(start),
        .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
        .fetch_count(fetch_count), .mac_count(mac_count)
    );

    int     tests = 0;
    int     fails = 0;
    longint exp_q[$];
    int     ma[SQ];
    int     mb[SQ];

    task automatic chk(bit ok, string req, longint act, longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic load_mats();
        for (int i = 0; i < SQ; i++) begin
            @(negedge clk);
            ld_a_we = 1'b1; ld_addr = AWD'(i); ld_data = DW'(ma[i]);
        end
        @(negedge clk); ld_a_we = 1'b0;
        for (int i = 0; i < SQ; i++) begin
            ld_b_we = 1'b1; ld_addr = AWD'(i); ld_data = DW'(mb[i]);
            @(negedge clk);
        end
        ld_b_we = 1'b0;
    endtask

    // Driver side of the scoreboard: expected products in read order.
    task automatic push_expected();
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                longint s = 0;
                for (int k = 0; k < N; k++) begin
                    s += longint'(ma[r*N+k]) * longint'(mb[k*N+c]);
                end
                exp_q.push_back(s);
            end
        end
    endtask

    // Monitor side: sweep the read port and compare against the queue.
    task automatic monitor(string req);
        for (int i = 0; i < SQ; i++) begin
            longint act, e;
            @(negedge clk);
            rd_addr = AWD'(i);
            #1;
            act = longint'($signed(rd_data));
            e   = exp_q.pop_front();
            chk(act == e, req, act, e);
        end
    endtask

    task automatic run(logic [1:0] m, int steps, int f, int mc, bit disturb, string req);
        int cyc = 0;
        @(negedge clk); mode = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3 && !done) begin
                start = 1'b1; mode = 2'd2;
                ld_a_we = 1'b1; ld_addr = '0; ld_data = 16'd999;
            end else if (disturb && cyc == 4) begin
                start = 1'b0; ld_a_we = 1'b0; mode = m;
            end
        end
        chk(cyc == steps, {req, " R6 latency"}, cyc, steps);
        chk(fetch_count == CW'(f), {req, " R7 fetch total"}, fetch_count, f);
        chk(mac_count == CW'(mc), {req, " R7 mac total"}, mac_count, mc);
        @(negedge clk);
        chk(done == 1'b0, {req, " R6 pulse width"}, done, 0);
    endtask

    initial begin
        #(8 * 200000);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_a_we = 0; ld_b_we = 0; ld_addr = '0; ld_data = '0;
        mode = 2'd0; start = 0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R6 reset done", done, 0);
        chk(fetch_count == '0, "R7 reset fetch", fetch_count, 0);
        chk(mac_count == '0, "R7 reset mac", mac_count, 0);
        chk(rd_data == '0, "R1 reset result", longint'(rd_data), 0);

        for (int i = 0; i < SQ; i++) begin
            ma[i] = i * 3 - 20;
            mb[i] = ((i * 7) % 23) - 11;
        end
        load_mats();

        push_expected(); run(2'd0, 64, 128, 64, 0, "R3 ijk"); monitor("R2 ijk result");
        push_expected(); run(2'd1, 16, 80, 64, 0, "R4 jki"); monitor("R1 R2 jki result");
        push_expected(); run(2'd2, 4, 32, 64, 0, "R5 kij"); monitor("R1 R2 kij result");

        repeat (10) @(negedge clk);
        push_expected(); monitor("R1 results held");
        chk(fetch_count == CW'(32), "R7 fetch held", fetch_count, 32);
        chk(mac_count == CW'(64), "R7 mac held", mac_count, 64);

        for (int i = 0; i < SQ; i++) begin
            ma[i] = -32768;
            mb[i] = -32768;
        end
        load_mats();
        push_expected(); run(2'd2, 4, 32, 64, 0, "R5 extreme"); monitor("R2 extreme kij");
        push_expected(); run(2'd0, 64, 128, 64, 0, "R3 extreme"); monitor("R2 extreme ijk");

        for (int i = 0; i < SQ; i++) begin
            mb[i] = (i % 2 == 0) ? 32767 : -32768;
        end
        load_mats();
        push_expected(); run(2'd1, 16, 80, 64, 0, "R4 mixed"); monitor("R2 mixed jki");

        push_expected(); run(2'd3, 64, 128, 64, 0, "R9 code3"); monitor("R9 code3 result");

        for (int i = 0; i < SQ; i++) begin
            ma[i] = (i * 11) % 17 - 8;
            mb[i] = 5 - i;
        end
        load_mats();
        push_expected(); run(2'd0, 64, 128, 64, 1, "R8 disturbed"); monitor("R8 disturbed result");
        push_expected(); run(2'd2, 4, 32, 64, 0, "R8 store intact"); monitor("R8 operand unchanged");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule